// File: doc/BRIEF.md
# Doorbell Message Handshake Engine

This block is the device-side half of a word-serial mailbox. A host reaches it through one 32-bit doorbell register and one interrupt-status register. The host opens a transfer by writing a start command that carries a request word count. It then feeds the request one 32-bit word at a time through the doorbell. Each word is handed to a local request buffer through a write port. The engine then returns a reply stored in a reply buffer, 16 bits per doorbell read.

The two sides pace each other with status flags. A device-to-host flag is raised for the start acknowledge, for every reply half-word and for the final completion. The host lowers it by writing the interrupt-status register. A host-to-device flag shows that a request word has not yet been taken. The reply is at least five words long. Its real length is picked up from the second half-word while the reply is being sent. The device state shown in the doorbell comes from outside the block.

Top module: `dbell_hs_engine`

## Requirements
- R1: After reset the engine is idle: doorbell bit 27 reads 0, the interrupt-status register reads 0, `proto_err` is 0 and `req_we` is 0.
- R2: Outside the reply phase, a doorbell read (offset 0x00) returns `dev_state` in bits 31:28, the busy flag in bit 27 and zeros elsewhere. An interrupt-status read (offset 0x30) returns the host-to-device flag in bit 31, the device-to-host flag in bit 0 and zeros elsewhere.
- R3: In idle, a doorbell write with 0x42 in bits 31:24 starts a handshake. Bits 23:16 give the request word count, busy becomes 1 and bit 0 is set as the acknowledge. A doorbell write in idle with any other value in bits 31:24 changes nothing.
- R4: Any write to the interrupt-status register clears bit 0 on the next clock.
- R5: While request words remain, a doorbell write latches the word and raises interrupt-status bit 31. On the following cycle `req_we` pulses once with that word and an index that counts from 0, and bit 31 drops.
- R6: In the reply phase the engine raises bit 0 for one half-word at a time, and only after the host has cleared bit 0. A doorbell read then returns the half-word in bits 15:0 with bits 31:16 zero. Half-words go out as the low half and then the high half of reply word 0, 1, 2, and so on, and `rep_addr` gives the word index.
- R7: The reply length in words is bits 23:16 of reply word 0, which is the low byte of the second half-word. The number of half-words sent is twice that length, and a length below 5 counts as 5.
- R8: After the host clears the last reply half-word, bit 0 is raised once more while busy still reads 1. Busy returns to 0 when the host clears that bit.
- R9: While busy, a doorbell write that cannot be taken as a request word is ignored and sets `proto_err`. This covers a write during the reply or completion phase, a write with no request words left, and a write while bit 31 is still 1. The next valid start clears `proto_err`.
- R10: A start with a word count of zero goes straight to the reply phase and makes no request-buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| dev_state | input | 4 | Device state shown in doorbell bits 31:28 |
| req_we | output | 1 | Request buffer write strobe |
| req_idx | output | RQ_AW (8) | Request buffer word index |
| req_data | output | 32 | Request buffer write data |
| rep_addr | output | 8 | Reply buffer word address |
| rep_data | input | 32 | Reply buffer word at `rep_addr`, same cycle |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that `rep_data` always reflects `rep_addr` in the same cycle and stays constant while a handshake is running. They also assume that one register access arrives per cycle, so a doorbell write and a status write never coincide. The bench keeps to this. It loads the reply buffer only while the engine is idle. Every access goes through tasks that poll bit 31 before sending a request word and bit 0 before reading a half-word. The one deliberate break in the protocol is a doorbell write injected mid-reply, which checks R9.

// File: rtl/dbhs_pkg.sv
package dbhs_pkg;
  localparam int CNT_W = 8;
  localparam int LEN_W = 8;
  localparam logic [7:0] HS_FUNC = 8'h42;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_REP  = 2'd2,
    HS_FIN  = 2'd3
  } hs_state_e;
endpackage

// File: rtl/dbhs_req_sink.sv
module dbhs_req_sink
  import dbhs_pkg::*;
#(
  parameter int RQ_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_word,
  input  logic [31:0]      wdata,
  output logic             acc,
  output logic             pend,
  output logic             drained,
  output logic             req_we,
  output logic [RQ_AW-1:0] req_idx,
  output logic [31:0]      req_data
);
  logic [CNT_W-1:0] left_q, left_n;
  logic             pend_q, pend_n;
  logic [31:0]      hold_q;
  logic             hold_en;
  logic [RQ_AW-1:0] idx_q, idx_n;

  always_comb begin
    acc     = wr_word && (left_q != '0) && !pend_q;
    hold_en = acc;
    pend_n  = acc;
    left_n  = left_q;
    if (start)    left_n = cnt;
    else if (acc) left_n = left_q - 1'b1;
    idx_n = idx_q;
    if (start)       idx_n = '0;
    else if (pend_q) idx_n = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      pend_q <= 1'b0;
      idx_q  <= '0;
      hold_q <= '0;
    end else begin
      left_q <= left_n;
      pend_q <= pend_n;
      idx_q  <= idx_n;
      if (hold_en) hold_q <= wdata;
    end
  end

  assign pend     = pend_q;
  assign req_we   = pend_q;
  assign req_idx  = idx_q;
  assign req_data = hold_q;
  assign drained  = (left_q == '0) && !pend_q;

  // R5
  one_cycle_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && !start) |=> (req_idx == $past(req_idx) + 1'b1));
endmodule

// File: rtl/dbhs_reply_seq.sv
module dbhs_reply_seq
  import dbhs_pkg::*;
#(
  parameter int MIN_WORDS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rep,
  input  logic             show,
  input  logic             adv,
  input  logic [31:0]      rep_data,
  output logic [LEN_W-1:0] rep_addr,
  output logic [15:0]      half,
  output logic             last
);
  localparam int HW_W = LEN_W + 1;
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_WORDS);

  logic [HW_W-1:0]  hidx_q, hidx_n;
  logic [HW_W-1:0]  total_q, total_n;
  logic [LEN_W-1:0] len_raw, len_eff;

  always_comb begin
    len_raw = rep_data[16 +: LEN_W];
    len_eff = (len_raw < MIN_L) ? MIN_L : len_raw;
    hidx_n  = hidx_q;
    if (start_rep) hidx_n = '0;
    else if (adv)  hidx_n = hidx_q + 1'b1;
    total_n = total_q;
    if (start_rep)                          total_n = {MIN_L, 1'b0};
    else if (show && hidx_q == HW_W'(1))    total_n = {len_eff, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hidx_q  <= '0;
      total_q <= '0;
    end else begin
      hidx_q  <= hidx_n;
      total_q <= total_n;
    end
  end

  assign rep_addr = hidx_q[HW_W-1:1];
  assign half     = hidx_q[0] ? rep_data[31:16] : rep_data[15:0];
  assign last     = (hidx_q == total_q - 1'b1);

  // R7
  reply_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (hidx_q < total_q));
endmodule

// File: rtl/dbhs_ctrl.sv
module dbhs_ctrl
  import dbhs_pkg::*;
#(
  parameter int            AW     = 8,
  parameter logic [AW-1:0] DB_OFS = 'h00,
  parameter logic [AW-1:0] IS_OFS = 'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       func,
  input  logic [CNT_W-1:0] cnt,
  input  logic             acc,
  input  logic             drained,
  input  logic             last,
  output hs_state_e        st,
  output logic             db_int,
  output logic             proto_err,
  output logic             start,
  output logic             wr_word,
  output logic             start_rep,
  output logic             show,
  output logic             adv
);
  hs_state_e st_q, st_n;
  logic      db_q, db_n;
  logic      sh_q, sh_n;
  logic      err_q, err_n;
  logic      wr_db, wr_is;

  always_comb begin
    wr_db     = reg_wr && (reg_addr == DB_OFS);
    wr_is     = reg_wr && (reg_addr == IS_OFS);
    st_n      = st_q;
    db_n      = db_q;
    sh_n      = sh_q;
    err_n     = err_q;
    start     = 1'b0;
    wr_word   = 1'b0;
    start_rep = 1'b0;
    show      = 1'b0;
    adv       = 1'b0;
    if (wr_is) db_n = 1'b0;
    unique case (st_q)
      HS_IDLE: begin
        if (wr_db && func == HS_FUNC) begin
          start = 1'b1;
          db_n  = 1'b1;
          sh_n  = 1'b0;
          err_n = 1'b0;
          if (cnt == '0) begin
            st_n      = HS_REP;
            start_rep = 1'b1;
          end else begin
            st_n = HS_REQ;
          end
        end
      end
      HS_REQ: begin
        if (wr_db) begin
          wr_word = 1'b1;
          if (!acc) err_n = 1'b1;
        end
        if (drained) begin
          st_n      = HS_REP;
          start_rep = 1'b1;
        end
      end
      HS_REP: begin
        if (wr_db) err_n = 1'b1;
        if (wr_is) begin
          if (sh_q) begin
            adv  = 1'b1;
            sh_n = 1'b0;
            if (last) st_n = HS_FIN;
          end
        end else if (!db_q && !sh_q) begin
          show = 1'b1;
          db_n = 1'b1;
          sh_n = 1'b1;
        end
      end
      HS_FIN: begin
        if (wr_db) err_n = 1'b1;
        if (wr_is) begin
          if (sh_q) begin
            sh_n = 1'b0;
            st_n = HS_IDLE;
          end
        end else if (!db_q && !sh_q) begin
          db_n = 1'b1;
          sh_n = 1'b1;
        end
      end
      default: st_n = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HS_IDLE;
      db_q  <= 1'b0;
      sh_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      db_q  <= db_n;
      sh_q  <= sh_n;
      err_q <= err_n;
    end
  end

  assign st        = st_q;
  assign db_int    = db_q;
  assign proto_err = err_q;

  // R3
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (db_int && st != HS_IDLE));

  // R4
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_is |=> !db_int);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(wr_db));

  // R8
  fin_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_IDLE && $past(st) == HS_FIN) |-> $past(wr_is));
endmodule

// File: rtl/dbell_hs_engine.sv
module dbell_hs_engine
  import dbhs_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] DB_OFS    = 'h00,
  parameter logic [AW-1:0] IS_OFS    = 'h30,
  parameter int            RQ_AW     = 8,
  parameter int            MIN_WORDS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [3:0]       dev_state,
  output logic             req_we,
  output logic [RQ_AW-1:0] req_idx,
  output logic [31:0]      req_data,
  output logic [LEN_W-1:0] rep_addr,
  input  logic [31:0]      rep_data,
  output logic             proto_err
);
  hs_state_e   st;
  logic        db_int, start, wr_word, start_rep, show, adv;
  logic        acc, pend, drained, last;
  logic [15:0] half;
  logic        busy;

  dbhs_ctrl #(.AW(AW), .DB_OFS(DB_OFS), .IS_OFS(IS_OFS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .func(reg_wdata[31:24]), .cnt(reg_wdata[23:16]),
    .acc(acc), .drained(drained), .last(last),
    .st(st), .db_int(db_int), .proto_err(proto_err), .start(start),
    .wr_word(wr_word), .start_rep(start_rep), .show(show), .adv(adv)
  );

  dbhs_req_sink #(.RQ_AW(RQ_AW)) u_sink (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt(reg_wdata[23:16]),
    .wr_word(wr_word), .wdata(reg_wdata), .acc(acc), .pend(pend),
    .drained(drained), .req_we(req_we), .req_idx(req_idx),
    .req_data(req_data)
  );

  dbhs_reply_seq #(.MIN_WORDS(MIN_WORDS)) u_reply (
    .clk(clk), .rst_n(rst_n), .start_rep(start_rep), .show(show),
    .adv(adv), .rep_data(rep_data), .rep_addr(rep_addr), .half(half),
    .last(last)
  );

  assign busy = (st != HS_IDLE);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == DB_OFS) begin
      if (st == HS_REP) reg_rdata = {16'h0000, half};
      else              reg_rdata = {dev_state, busy, 27'h0};
    end else if (reg_addr == IS_OFS) begin
      reg_rdata = {pend, 30'h0, db_int};
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_we);

  // R6
  reply_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    show |=> (busy && db_int));
endmodule

// File: tb/sim_dbell_hs_engine.sv
module sim_dbell_hs_engine;
  localparam int CLK_P = 10;
  localparam logic [7:0] DB = 8'h00;
  localparam logic [7:0] IS = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  dev_state;
  logic        req_we;
  logic [7:0]  req_idx;
  logic [31:0] req_data;
  logic [7:0]  rep_addr;
  logic [31:0] rep_data;
  logic        proto_err;

  logic [31:0] rmem [256];
  logic [39:0] exp_q [$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rep_data = rmem[rep_addr];

  dbell_hs_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_state(dev_state),
    .req_we(req_we), .req_idx(req_idx), .req_data(req_data),
    .rep_addr(rep_addr), .rep_data(rep_data), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_int(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 40; i++) begin
      rd(IS, v);
      if (v[0]) begin
        ok = 1;
        break;
      end
    end
  endtask

  // scoreboard driver: push expected request-buffer writes, then send words
  task automatic send_req(input int n, input logic [31:0] base);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = base ^ (32'h0101_0101 * (i + 1));
      for (int k = 0; k < 20; k++) begin
        rd(IS, v);
        if (!v[31]) break;
      end
      exp_q.push_back({8'(i), w});
      @(negedge clk);
      reg_addr  = DB;
      reg_wdata = w;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr   = 1'b0;
      reg_addr = IS;
      #1 chk(reg_rdata[31] == 1'b1, "R5 bit31 after word", reg_rdata, 32'h8000_0000);
    end
  endtask

  function automatic logic [15:0] exp_half(input int i);
    return (i % 2 == 1) ? rmem[i/2][31:16] : rmem[i/2][15:0];
  endfunction

  task automatic get_reply(input int nh, input int inject_at);
    logic [31:0] v;
    bit ok;
    for (int i = 0; i < nh; i++) begin
      wait_int(ok);
      chk(ok, "R6 half-word flag", {31'h0, ok}, 32'h1);
      if (i == inject_at) begin
        wr(DB, 32'h4202_0000);
        chk(proto_err == 1'b1, "R9 error on write in reply", {31'h0, proto_err}, 32'h1);
      end
      rd(DB, v);
      chk(v == {16'h0, exp_half(i)}, "R6/R7 reply half-word", v, {16'h0, exp_half(i)});
      wr(IS, 32'h0);
    end
    wait_int(ok);
    chk(ok, "R8 completion flag", {31'h0, ok}, 32'h1);
    rd(DB, v);
    chk(v == {dev_state, 1'b1, 27'h0}, "R8 busy during completion", v, {dev_state, 1'b1, 27'h0});
    wr(IS, 32'h0);
    rd(DB, v);
    chk(v == {dev_state, 1'b0, 27'h0}, "R8 idle after completion", v, {dev_state, 1'b0, 27'h0});
  endtask

  // scoreboard monitor
  initial begin
    logic [39:0] e;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && req_we === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected req write", {24'h0, req_idx}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(req_idx == e[39:32], "R5 req index", {24'h0, req_idx}, {24'h0, e[39:32]});
          chk(req_data == e[31:0], "R5 req data", req_data, e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-any act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++)
      rmem[i] = {8'(i), 8'(i + 1), 8'(~i), 8'(i ^ 8'h3c)};
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_addr = DB;
    reg_wdata = '0;
    dev_state = 4'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 reset state
    rd(DB, v);
    chk(v == 32'h1000_0000, "R1 doorbell idle", v, 32'h1000_0000);
    rd(IS, v);
    chk(v == 32'h0, "R1 status clear", v, 32'h0);
    chk(proto_err == 1'b0, "R1 no error", {31'h0, proto_err}, 32'h0);

    // R3 other function code ignored in idle
    wr(DB, 32'h4005_0000);
    rd(DB, v);
    chk(v == 32'h1000_0000, "R3 non-start ignored", v, 32'h1000_0000);
    chk(proto_err == 1'b0, "R3 no error on idle write", {31'h0, proto_err}, 32'h0);

    // Test 1: three request words, reply length 7 words
    dev_state = 4'h2;
    rmem[0] = 32'h0007_A5A5;
    wr(DB, 32'h4203_0000);
    rd(IS, v);
    chk(v == 32'h1, "R3 start acknowledge", v, 32'h1);
    rd(DB, v);
    chk(v == 32'h2800_0000, "R2 busy with state", v, 32'h2800_0000);
    wr(IS, 32'h0);
    rd(IS, v);
    chk(v == 32'h0, "R4 status write clears", v, 32'h0);
    send_req(3, 32'hC0DE_0000);
    get_reply(14, 3);
    chk(exp_q.size() == 0, "R5 all words written", exp_q.size(), 0);

    // Test 2: zero count, short length floored at 5 words
    rmem[0] = 32'h0002_3C3C;
    wr(DB, 32'h4200_0000);
    chk(proto_err == 1'b0, "R9 start clears error", {31'h0, proto_err}, 32'h0);
    wr(IS, 32'h0);
    get_reply(10, -1);

    // Test 3: one request word, length exactly 5
    dev_state = 4'h4;
    rmem[0] = 32'h0005_1111;
    wr(DB, 32'h4201_0000);
    wr(IS, 32'h0);
    send_req(1, 32'h0BAD_F00D);
    get_reply(10, -1);
    chk(exp_q.size() == 0, "R10 no stray writes", exp_q.size(), 0);
    chk(proto_err == 1'b0, "R9 clean run", {31'h0, proto_err}, 32'h0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule